// File: doc/BRIEF.md
# Sequential Multiply-Accumulate Neuron with Table Activation

This block is one digital neuron in a layered feed-forward network. The 8-bit states of all neurons in the previous layer arrive over a narrow input link. That link has LANES wires, and each 8-bit word takes 8/LANES transfers, most significant slice first. The block puts each finished word into a local activation store. The words fill the store in arrival order: first the NUM_SRC source states, then one bias word, after which the write pointer wraps back to slot 0. Weights sit in a separate store, which has its own address and data write port.

A one-cycle start pulse begins an evaluation. The bias goes into the upper byte of a 16-bit accumulator, with the lower byte cleared. One 8x8 signed multiplier then handles one source per cycle, and each product is added to the accumulator with saturation. Once every product has been added, the upper byte of the sum indexes a 256-entry transfer-function table. The table value is flagged with a one-cycle done pulse and is sent out over an output link of the same lane width.

Top module: `neuron_mac_top`

## Requirements
- R1: The input link assembles a word from 8/LANES consecutive valid transfers, first transfer in the most significant bits. `rx_word_ready` is high for exactly the one cycle after the edge that takes the final transfer.
- R2: Completed words are stored in order. Words 0..NUM_SRC-1 are the source activations, word NUM_SRC is the bias, and the next word goes to slot 0 again.
- R3: A write with `wt_we` high stores the signed value on `wt_data` as the weight of the source given by `wt_addr`. Only that source's contribution uses it.
- R4: An evaluation starts with the accumulator at bias*256 and adds activation[i]*weight[i] for every source. All values are two's-complement.
- R5: After each addition the accumulator saturates at +32767 and -32768. It never wraps, and later products work from the clamped value.
- R6: The output word is f(s), where s is the signed upper byte of the final sum (floor of sum/256). f(s) = -128 for s < -64, f(s) = 127 for s >= 64, and f(s) = 2*s otherwise.
- R7: `done` is a one-cycle pulse at the (NUM_SRC+2)th rising edge, counting the edge that samples `start` as the first.
- R8: `tx_valid` is high for 8/LANES consecutive cycles, starting in the same cycle as `done`. Each cycle carries the next LANES-bit slice of the output word on `tx_lanes`, most significant slice first.
- R9: A `start` that arrives while an evaluation or its transmission is in progress is ignored. It causes no second `done` and does not change the output word.
- R10: After reset, `done`, `tx_valid`, `rx_word_ready` and `tx_lanes` are zero, and all stored activations, the bias and all weights are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Input link transfer valid |
| rx_lanes | input | LANES | Input link data slice |
| rx_word_ready | output | 1 | One-cycle pulse when a word has been stored |
| wt_we | input | 1 | Weight write enable |
| wt_addr | input | clog2(NUM_SRC) | Source index of the weight write |
| wt_data | input | 8 | Signed weight value |
| start | input | 1 | Begin an evaluation |
| done | output | 1 | One-cycle pulse marking the first output transfer |
| tx_valid | output | 1 | Output link transfer valid |
| tx_lanes | output | LANES | Output link data slice |

## Verification
Results are due at fixed times. `rx_word_ready` comes one cycle after the final transfer of a word. `done` and the first output slice come NUM_SRC+1 edges after the edge that takes `start`. The remaining slices follow on the next consecutive cycles, and a new `start` is accepted only after the last slice has left. The bench model counts edges from the sampled start in the same way and predicts the four outputs for every cycle. It compares them half a period after each edge, so every result is checked in the exact cycle it is due. Separate scenarios check the assembled output word against values worked out by hand for saturation, recovery after clamping, floor rounding of negative sums, a single weight address, and an ignored start.

// File: rtl/neuron_mac_pkg.sv
package neuron_mac_pkg;

    localparam int ACT_W = 8;
    localparam int ACC_W = 16;

    typedef logic signed [ACT_W-1:0] act_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MAC,
        ST_LOOK,
        ST_SEND
    } core_st_e;

    // Add with clamping to the signed 16-bit range.
    function automatic acc_t sat_add(input acc_t a, input acc_t p);
        logic [ACC_W:0] s;
        s = {a[ACC_W-1], a} + {p[ACC_W-1], p};
        if (s[ACC_W:ACC_W-1] == 2'b01) return acc_t'(16'h7FFF);
        if (s[ACC_W:ACC_W-1] == 2'b10) return acc_t'(16'h8000);
        return acc_t'(s[ACC_W-1:0]);
    endfunction

    // Saturating ramp transfer function used to fill the lookup table.
    function automatic act_t xfer_fn(input act_t s);
        if (s < -8'sd64) return -8'sd128;
        if (s >= 8'sd64) return 8'sd127;
        return act_t'({s[ACT_W-2:0], 1'b0});
    endfunction

endpackage

// File: rtl/neuron_link_rx.sv
module neuron_link_rx
    import neuron_mac_pkg::*;
#(
    parameter int NUM_SRC = 10,
    parameter int LANES   = 4,
    localparam int BEATS  = 8 / LANES,
    localparam int BCW    = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int DEPTH  = NUM_SRC + 1,
    localparam int AW     = $clog2(DEPTH),
    localparam int IW     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [LANES-1:0] rx_lanes,
    output logic             rx_word_ready,
    input  logic [IW-1:0]    rd_addr,
    output act_t             rd_act,
    output act_t             bias_q
);

    logic [BCW-1:0] beat_cnt;
    logic [7:0]     shreg;
    logic [7:0]     word_full;
    logic [AW-1:0]  wptr;
    act_t           mem [DEPTH];

    if (!(LANES == 1 || LANES == 2 || LANES == 4 || LANES == 8)) begin : g_bad_lanes
        $error("LANES must be 1, 2, 4 or 8");
    end

    if (LANES == 8) begin : g_full
        assign word_full = rx_lanes;
    end else begin : g_part
        assign word_full = {shreg[7-LANES:0], rx_lanes};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_cnt      <= '0;
            shreg         <= '0;
            wptr          <= '0;
            rx_word_ready <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            rx_word_ready <= 1'b0;
            if (rx_valid) begin
                shreg <= word_full;
                if (beat_cnt == BCW'(BEATS - 1)) begin
                    beat_cnt      <= '0;
                    mem[wptr]     <= act_t'(word_full);
                    wptr          <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
                    rx_word_ready <= 1'b1;
                end else begin
                    beat_cnt <= beat_cnt + 1'b1;
                end
            end
        end
    end

    assign rd_act = mem[rd_addr];
    assign bias_q = mem[NUM_SRC];

    // R1
    rdy_after_beat_chk: assert property (@(posedge clk) disable iff (rst)
        rx_word_ready |-> $past(rx_valid));

endmodule

// File: rtl/neuron_mac_core.sv
module neuron_mac_core
    import neuron_mac_pkg::*;
#(
    parameter int NUM_SRC = 10,
    localparam int IW     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  act_t          act_q,
    input  act_t          wt_q,
    input  act_t          bias_q,
    input  logic          tx_last,
    output logic [IW-1:0] rd_idx,
    output logic          done,
    output logic          load_tx,
    output act_t          result
);

    core_st_e state;
    acc_t     acc;
    acc_t     prod;
    act_t     lut [256];

    for (genvar g = 0; g < 256; g++) begin : g_lut
        assign lut[g] = xfer_fn(act_t'(g));
    end

    assign prod    = act_q * wt_q;
    assign load_tx = (state == ST_LOOK);
    assign result  = lut[acc[ACC_W-1:ACC_W-8]];

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            acc    <= '0;
            rd_idx <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    acc    <= acc_t'({bias_q, 8'h00});
                    rd_idx <= '0;
                    state  <= ST_MAC;
                end
                ST_MAC: begin
                    acc <= sat_add(acc, prod);
                    if (rd_idx == IW'(NUM_SRC - 1)) state <= ST_LOOK;
                    else rd_idx <= rd_idx + 1'b1;
                end
                ST_LOOK: begin
                    done  <= 1'b1;
                    state <= ST_SEND;
                end
                default: if (tx_last) state <= ST_IDLE;
            endcase
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    sat_high_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MAC && !acc[ACC_W-1] && !prod[ACC_W-1]) |=> !acc[ACC_W-1]);

    // R5
    sat_low_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MAC && acc[ACC_W-1] && prod[ACC_W-1]) |=> acc[ACC_W-1]);

endmodule

// File: rtl/neuron_link_tx.sv
module neuron_link_tx
    import neuron_mac_pkg::*;
#(
    parameter int LANES  = 4,
    localparam int BEATS = 8 / LANES,
    localparam int CW    = $clog2(BEATS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  act_t             word_in,
    output logic             tx_valid,
    output logic [LANES-1:0] tx_lanes,
    output logic             tx_last
);

    logic [7:0]    sh;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            cnt <= '0;
        end else if (load) begin
            sh  <= word_in;
            cnt <= CW'(BEATS);
        end else if (cnt != '0) begin
            sh  <= sh << LANES;
            cnt <= cnt - 1'b1;
        end
    end

    assign tx_valid = (cnt != '0);
    assign tx_last  = (cnt == CW'(1));
    assign tx_lanes = sh[7 -: LANES];

    // R8
    beat_run_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_last) |=> tx_valid);

endmodule

// File: rtl/neuron_mac_top.sv
module neuron_mac_top
    import neuron_mac_pkg::*;
#(
    parameter int NUM_SRC = 10,
    parameter int LANES   = 4,
    localparam int WAW    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [LANES-1:0] rx_lanes,
    output logic             rx_word_ready,
    input  logic             wt_we,
    input  logic [WAW-1:0]   wt_addr,
    input  logic [7:0]       wt_data,
    input  logic             start,
    output logic             done,
    output logic             tx_valid,
    output logic [LANES-1:0] tx_lanes
);

    logic [WAW-1:0] rd_idx;
    act_t           act_q;
    act_t           bias_q;
    act_t           result;
    logic           load_tx;
    logic           tx_last;
    act_t           wmem [NUM_SRC];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SRC; i++) wmem[i] <= '0;
        end else if (wt_we && (int'(wt_addr) < NUM_SRC)) begin
            wmem[wt_addr] <= act_t'(wt_data);
        end
    end

    neuron_link_rx #(.NUM_SRC(NUM_SRC), .LANES(LANES)) u_rx (
        .clk           (clk),
        .rst           (rst),
        .rx_valid      (rx_valid),
        .rx_lanes      (rx_lanes),
        .rx_word_ready (rx_word_ready),
        .rd_addr       (rd_idx),
        .rd_act        (act_q),
        .bias_q        (bias_q)
    );

    neuron_mac_core #(.NUM_SRC(NUM_SRC)) u_core (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .act_q   (act_q),
        .wt_q    (wmem[rd_idx]),
        .bias_q  (bias_q),
        .tx_last (tx_last),
        .rd_idx  (rd_idx),
        .done    (done),
        .load_tx (load_tx),
        .result  (result)
    );

    neuron_link_tx #(.LANES(LANES)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .load     (load_tx),
        .word_in  (result),
        .tx_valid (tx_valid),
        .tx_lanes (tx_lanes),
        .tx_last  (tx_last)
    );

    // R8
    done_tx_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> tx_valid);

endmodule

// File: tb/neuron_mac_top_test.sv
`timescale 1ns/1ps
module neuron_mac_top_test;

    localparam int N    = 10;
    localparam int T    = 4;
    localparam int B    = 8 / T;
    localparam int WAW  = $clog2(N);
    localparam int MASK = (1 << T) - 1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           rx_valid = 1'b0;
    logic [T-1:0]   rx_lanes = '0;
    logic           rx_word_ready;
    logic           wt_we = 1'b0;
    logic [WAW-1:0] wt_addr = '0;
    logic [7:0]     wt_data = '0;
    logic           start = 1'b0;
    logic           done;
    logic           tx_valid;
    logic [T-1:0]   tx_lanes;

    int n_chk = 0;
    int n_fail = 0;

    neuron_mac_top #(.NUM_SRC(N), .LANES(T)) uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_lanes(rx_lanes),
        .rx_word_ready(rx_word_ready), .wt_we(wt_we), .wt_addr(wt_addr),
        .wt_data(wt_data), .start(start), .done(done), .tx_valid(tx_valid),
        .tx_lanes(tx_lanes)
    );

    always #2.5 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int m_act[N+1];
    int m_wt[N];
    int m_ptr, m_beats, m_word, mk, m_res;
    bit mbusy;
    bit e_wr, e_done, e_txv;
    int e_lanes;

    function automatic int f_ref(int s);
        if (s < -64) return -128;
        if (s >= 64) return 127;
        return 2 * s;
    endfunction

    function automatic int ref_eval();
        int acc;
        acc = m_act[N] * 256;
        for (int i = 0; i < N; i++) begin
            acc = acc + m_act[i] * m_wt[i];
            if (acc > 32767) acc = 32767;
            if (acc < -32768) acc = -32768;
        end
        return f_ref(acc >>> 8) & 255;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i <= N; i++) m_act[i] = 0;
            for (int i = 0; i < N; i++) m_wt[i] = 0;
            m_ptr = 0; m_beats = 0; m_word = 0; mk = 0; m_res = 0; mbusy = 0;
            e_wr = 0; e_done = 0; e_txv = 0; e_lanes = 0;
        end else begin
            e_wr = 0;
            if (rx_valid) begin
                m_word = (m_word << T) | int'(rx_lanes);
                m_beats++;
                if (m_beats == B) begin
                    m_act[m_ptr] = (m_word > 127) ? m_word - 256 : m_word;
                    m_ptr = (m_ptr == N) ? 0 : m_ptr + 1;
                    m_beats = 0;
                    m_word = 0;
                    e_wr = 1;
                end
            end
            if (wt_we && int'(wt_addr) < N) m_wt[wt_addr] = int'($signed(wt_data));
            if (mbusy) begin
                mk++;
                if (mk > N + B + 1) mbusy = 0;
            end
            if (!mbusy && start) begin
                mbusy = 1;
                mk = 0;
                m_res = ref_eval();
            end
            e_done = mbusy && (mk == N + 1);
            e_txv  = mbusy && (mk >= N + 1) && (mk <= N + B);
            e_lanes = e_txv ? ((m_res >> (8 - T * (mk - N))) & MASK) : 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison, half a period after each edge
    always @(negedge clk) begin
        if (!rst) begin
            check(rx_word_ready == e_wr, "R1 rx_word_ready", int'(rx_word_ready), int'(e_wr));
            check(done == e_done, "R7 done", int'(done), int'(e_done));
            check(tx_valid == e_txv, "R8 tx_valid", int'(tx_valid), int'(e_txv));
            check(int'(tx_lanes) == e_lanes, "R6 tx_lanes", int'(tx_lanes), e_lanes);
        end
    end

    // ---------------- stimulus ----------------
    int acts[N];

    task automatic send_word(input int w);
        for (int j = 0; j < B; j++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_lanes = T'((w >> (8 - T * (j + 1))) & MASK);
        end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic load_acts(input int bias);
        for (int i = 0; i < N; i++) send_word(acts[i] & 255);
        send_word(bias & 255);
    endtask

    task automatic set_wt(input int a, input int v);
        @(negedge clk);
        wt_we = 1'b1;
        wt_addr = WAW'(a);
        wt_data = 8'(v);
        @(negedge clk);
        wt_we = 1'b0;
    endtask

    task automatic set_all(input int a, input int w);
        for (int i = 0; i < N; i++) begin
            acts[i] = a;
            set_wt(i, w);
        end
    endtask

    task automatic run_eval(input int exp_word, input string req, input bit extra_start);
        int word;
        int beats;
        int dones;
        word = 0; beats = 0; dones = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 60; c++) begin
            if (extra_start && c == 3) start = 1'b1;
            if (extra_start && c == 4) start = 1'b0;
            if (tx_valid) begin
                word = (word << T) | int'(tx_lanes);
                beats++;
            end
            if (done) dones++;
            @(negedge clk);
        end
        check((word & 255) == exp_word, req, word & 255, exp_word);
        check(beats == B, "R8 beat count", beats, B);
        check(dones == 1, extra_start ? "R9 single done" : "R7 single done", dones, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state at the ports
        check(done == 0 && tx_valid == 0 && rx_word_ready == 0 && tx_lanes == 0,
              "R10 reset outputs", int'({done, tx_valid, rx_word_ready}), 0);
        run_eval(8'h00, "R10 zeroed stores", 1'b0);

        // R4: bias only, 5*256 -> s=5 -> 10
        for (int i = 0; i < N; i++) acts[i] = 0;
        load_acts(5);
        run_eval(8'h0A, "R4 bias only", 1'b0);

        // R5: positive clamp
        set_all(127, 127);
        load_acts(0);
        run_eval(8'h7F, "R5 positive clamp", 1'b0);

        // R5: negative clamp
        set_all(127, -128);
        load_acts(0);
        run_eval(8'h80, "R5 negative clamp", 1'b0);

        // R5: recovery from clamped value: 3*16129 clamps to 32767, minus 2*16256 = 255 -> 0
        for (int i = 0; i < N; i++) set_wt(i, (i < 3) ? 127 : ((i < 5) ? -128 : 0));
        load_acts(0);
        run_eval(8'h00, "R5 clamp then recover", 1'b0);

        // R6/R2: a0*w0 = 6400, bias -3 -> 5632 -> s=22 -> 44
        set_all(0, 0);
        acts[0] = 64;
        set_wt(0, 100);
        load_acts(-3);
        run_eval(8'h2C, "R2 R6 mid ramp", 1'b0);

        // R6: floor of -1/256 is -1 -> -2
        acts[0] = -1;
        set_wt(0, 1);
        load_acts(0);
        run_eval(8'hFE, "R6 floor negative", 1'b0);

        // R6: bias -40 -> s=-40 -> -80
        acts[0] = 0;
        load_acts(-40);
        run_eval(8'hB0, "R6 negative ramp", 1'b0);

        // R3: only source 9 weighted: 50*-50 = -2500 -> s=-10 -> -20
        set_wt(0, 0);
        acts[9] = 50;
        set_wt(9, -50);
        load_acts(0);
        run_eval(8'hEC, "R3 weight address", 1'b0);

        // R9: start during evaluation ignored
        run_eval(8'hEC, "R9 start while busy", 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule